// File: doc/BRIEF.md
# Serial NOR Flash Target Interface with Pause Input

This block is the device side of a small serial NOR flash. A host frames each transaction by pulling the active-low select low. It then clocks an 8-bit command, and for memory commands a 24-bit address, into the device. Data then flows in one of two directions. For reads it comes out of a small register-backed byte array or out of two status registers. For writes it goes into the array or into those registers. Transfers use one, two or four data lines depending on the command.

The serial pins are oversampled by the block's own clock. Serial input bits are taken when the serial clock rises, and output bits change after it falls. While the block is not selected it drives no data line. With quad mode disabled, IO2 is the active-low write-protect pin and IO3 is the active-low pause pin. Pausing freezes a transaction without ending it: the outputs float and clock edges are ignored until the pause is lifted. Setting the quad-enable bit in status register 2 turns both pins into plain data lines.

Top module: `flash_serial_slave`

## Requirements
- R1: While cs_n is high, io_oe is 4'b0000 within three clk cycles. Raising cs_n also discards any partly received command, so the next selection starts a fresh 8-bit command.
- R2: Commands and addresses arrive most significant bit first on IO0, one bit per rising SCLK edge. The address is 24 bits, and bits above the array index width are ignored.
- R3: Command 0x03 returns array bytes on IO1, most significant bit first. Each bit changes after a falling SCLK edge, starting with the falling edge that follows the last address bit. io_oe is 4'b0010 while bits are returned.
- R4: Read and program addresses advance by one per byte and wrap from DEPTH-1 back to 0.
- R5: With quad mode off and the device selected, a low IO3 pauses the transfer. While paused, io_oe is 4'b0000 and SCLK and the data inputs are ignored. Once IO3 returns high, the transfer continues from the same bit.
- R6: Status register 1 holds a busy flag in bit 0 (always 0), the write-enable latch in bit 1, and writable bits in 7:2. Status register 2 is fully writable, and bit 1 is the quad-enable bit. Command 0x05 returns register 1 and command 0x35 returns register 2, repeated for as long as clocks continue.
- R7: Command 0x06 sets the write-enable latch. The latch is cleared when cs_n rises at the end of a 0x01 command or an accepted 0x32 command. It is not cleared at the end of other commands.
- R8: Command 0x01 writes its first data byte to status register 1 and its second to status register 2. Each byte is stored only if the write-enable latch is set and write-protect is not asserted. Write-protect is asserted when quad mode is off and IO2 is low.
- R9: With quad-enable set, the levels on IO2 and IO3 neither block status writes nor pause transfers.
- R10: Command 0x3B takes an address followed by 8 dummy clocks, during which io_oe is 4'b0000. It then returns two bits per clock on IO1:IO0, with IO1 carrying the higher bit, and io_oe is 4'b0011.
- R11: Command 0x6B takes an address followed by 8 dummy clocks with io_oe 4'b0000. It then returns a nibble per clock on IO3:IO0, high nibble first with IO3 as the most significant bit, and io_oe is 4'b1111. With quad-enable clear, the command is ignored.
- R12: Command 0x32 takes an address and then captures a nibble per rising edge on IO3:IO0, high nibble first. Each completed byte is stored at the next address in turn. Bytes are stored only when quad-enable and the write-enable latch are both set; with quad-enable clear, the command is ignored.
- R13: Any other command drives nothing until cs_n rises.
- R14: After reset, array byte i holds (29*i + 0x5A) mod 256, and both status registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low reset |
| sclk | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low device select |
| io_in | input | 4 | Pin levels of IO3..IO0 (IO2 is write-protect and IO3 is pause when quad mode is off) |
| io_out | output | 4 | Values driven onto IO3..IO0 |
| io_oe | output | 4 | Per-line output enables for IO3..IO0 |

## Verification
A wrong bit counter or phase state shows up at the ports within one transaction. Returned data comes out shifted or from the wrong address, or io_oe takes the wrong lane pattern at the first falling edge after the command. A corrupted write-enable latch or quad-enable bit is only visible through a later status read, or through a program or quad read that should or should not take effect. So each such state is read back in the transaction that immediately follows the one that set it. Pause faults show as enabled outputs while IO3 is low, or as data that skips bits after release.

// File: rtl/flash_pkg.sv
package flash_pkg;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DOUT,
        ST_QIN,
        ST_WSR,
        ST_IGNORE
    } fstate_e;

    typedef enum logic [1:0] {
        LN_1,
        LN_2,
        LN_4
    } lanes_e;

    typedef enum logic [1:0] {
        SRC_MEM,
        SRC_SR1,
        SRC_SR2
    } src_e;

    localparam logic [7:0] OP_STAT1_RD  = 8'h05;
    localparam logic [7:0] OP_STAT2_RD  = 8'h35;
    localparam logic [7:0] OP_WR_ENABLE = 8'h06;
    localparam logic [7:0] OP_STAT_WR   = 8'h01;
    localparam logic [7:0] OP_READ_X1   = 8'h03;
    localparam logic [7:0] OP_READ_X2   = 8'h3B;
    localparam logic [7:0] OP_READ_X4   = 8'h6B;
    localparam logic [7:0] OP_PROG_X4   = 8'h32;

    typedef struct packed {
        logic       sclk;
        logic       sclk_p;
        logic       cs_n;
        logic [3:0] io;
    } pin_t;

    function automatic logic [3:0] lane_mask(lanes_e l);
        case (l)
            LN_1:    return 4'b0010;
            LN_2:    return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [2:0] lane_reload(lanes_e l);
        case (l)
            LN_1:    return 3'd7;
            LN_2:    return 3'd3;
            default: return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/flash_pin_sampler.sv
module flash_pin_sampler
    import flash_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic [3:0] io_in,
    input  logic       qe,
    output logic       sel,
    output logic       rise,
    output logic       fall,
    output logic [3:0] io_s,
    output logic       hold_act,
    output logic       wp_act
);

    pin_t pin_d, pin_q;

    always_comb begin
        pin_d        = pin_q;
        pin_d.sclk   = sclk;
        pin_d.sclk_p = pin_q.sclk;
        pin_d.cs_n   = cs_n;
        pin_d.io     = io_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= '{sclk: 1'b0, sclk_p: 1'b0, cs_n: 1'b1, io: 4'b1100};
        end else begin
            pin_q <= pin_d;
        end
    end

    always_comb begin
        sel      = ~pin_q.cs_n;
        io_s     = pin_q.io;
        hold_act = sel & ~qe & ~pin_q.io[3];
        wp_act   = ~qe & ~pin_q.io[2];
        rise     = sel & ~hold_act & pin_q.sclk & ~pin_q.sclk_p;
        fall     = sel & ~hold_act & ~pin_q.sclk & pin_q.sclk_p;
    end

endmodule

// File: rtl/flash_store.sv
module flash_store #(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'((i * 29) + 90);
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
    import flash_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int ADDR_BITS  = 24,
    parameter int DUMMY_CLKS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              rise,
    input  logic              fall,
    input  logic [3:0]        io_s,
    input  logic              wp_act,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata,
    output logic [3:0]        lane_oe,
    output logic [3:0]        lane_out,
    output logic              qe,
    output logic              wel,
    output logic [7:0]        sr2,
    output fstate_e           fsm_st,
    output logic [$clog2(ADDR_BITS)-1:0] fsm_cnt
);

    localparam int CNT_W = $clog2(ADDR_BITS);
    localparam int DC_W  = $clog2(DUMMY_CLKS + 1);

    typedef struct packed {
        fstate_e           st;
        logic [CNT_W-1:0]  cnt;
        logic [7:0]        sh;
        lanes_e            ln;
        src_e              src;
        logic              dummy_en;
        logic              prog;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        ob;
        logic [2:0]        oc;
        logic [3:0]        oe;
        logic [3:0]        dout;
        logic              wel;
        logic [5:0]        sr1h;
        logic [7:0]        sr2;
        logic              wr_cmd;
        logic [DC_W-1:0]   dcnt;
        logic              wsr_idx;
    } eng_t;

    eng_t eng_d, eng_q;

    logic [7:0] opc;
    logic [7:0] byte_in;
    logic [7:0] fresh;
    logic [7:0] cur;
    logic       wr_ok;

    always_comb begin
        eng_d     = eng_q;
        mem_we    = 1'b0;
        mem_waddr = eng_q.addr;
        mem_wdata = 8'h00;
        opc       = {eng_q.sh[6:0], io_s[0]};
        byte_in   = {eng_q.sh[6:0], io_s[0]};
        wr_ok     = eng_q.wel & ~wp_act;
        cur       = eng_q.ob;

        case (eng_q.src)
            SRC_SR1: fresh = {eng_q.sr1h, eng_q.wel, 1'b0};
            SRC_SR2: fresh = eng_q.sr2;
            default: fresh = mem_rdata;
        endcase

        if (!sel) begin
            eng_d.st      = ST_CMD;
            eng_d.cnt     = '0;
            eng_d.oe      = 4'b0000;
            eng_d.oc      = 3'd0;
            eng_d.dcnt    = '0;
            eng_d.wsr_idx = 1'b0;
            eng_d.wr_cmd  = 1'b0;
            if (eng_q.wr_cmd) begin
                eng_d.wel = 1'b0;
            end
        end else if (rise) begin
            case (eng_q.st)
                ST_CMD: begin
                    eng_d.sh  = byte_in;
                    eng_d.cnt = eng_q.cnt + 1'b1;
                    if (eng_q.cnt == CNT_W'(7)) begin
                        eng_d.cnt      = '0;
                        eng_d.prog     = 1'b0;
                        eng_d.dummy_en = 1'b0;
                        eng_d.ln       = LN_1;
                        eng_d.src      = SRC_MEM;
                        eng_d.st       = ST_IGNORE;
                        case (opc)
                            OP_STAT1_RD: begin
                                eng_d.st  = ST_DOUT;
                                eng_d.src = SRC_SR1;
                            end
                            OP_STAT2_RD: begin
                                eng_d.st  = ST_DOUT;
                                eng_d.src = SRC_SR2;
                            end
                            OP_WR_ENABLE: begin
                                eng_d.wel = 1'b1;
                            end
                            OP_STAT_WR: begin
                                eng_d.st     = ST_WSR;
                                eng_d.wr_cmd = 1'b1;
                            end
                            OP_READ_X1: begin
                                eng_d.st = ST_ADDR;
                            end
                            OP_READ_X2: begin
                                eng_d.st       = ST_ADDR;
                                eng_d.ln       = LN_2;
                                eng_d.dummy_en = 1'b1;
                            end
                            OP_READ_X4: begin
                                if (eng_q.sr2[1]) begin
                                    eng_d.st       = ST_ADDR;
                                    eng_d.ln       = LN_4;
                                    eng_d.dummy_en = 1'b1;
                                end
                            end
                            OP_PROG_X4: begin
                                if (eng_q.sr2[1]) begin
                                    eng_d.st     = ST_ADDR;
                                    eng_d.prog   = 1'b1;
                                    eng_d.wr_cmd = 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                ST_ADDR: begin
                    eng_d.addr = ADDR_W'({eng_q.addr, io_s[0]});
                    eng_d.cnt  = eng_q.cnt + 1'b1;
                    if (eng_q.cnt == CNT_W'(ADDR_BITS - 1)) begin
                        eng_d.cnt = '0;
                        if (eng_q.prog) begin
                            eng_d.st = ST_QIN;
                        end else if (eng_q.dummy_en) begin
                            eng_d.st = ST_DUMMY;
                        end else begin
                            eng_d.st = ST_DOUT;
                        end
                    end
                end
                ST_DUMMY: begin
                    eng_d.dcnt = eng_q.dcnt + 1'b1;
                    if (eng_q.dcnt == DC_W'(DUMMY_CLKS - 1)) begin
                        eng_d.st = ST_DOUT;
                    end
                end
                ST_QIN: begin
                    eng_d.sh  = {eng_q.sh[3:0], io_s};
                    eng_d.cnt = eng_q.cnt + 1'b1;
                    if (eng_q.cnt[0]) begin
                        eng_d.cnt  = '0;
                        eng_d.addr = eng_q.addr + 1'b1;
                        mem_wdata  = {eng_q.sh[3:0], io_s};
                        mem_we     = eng_q.wel;
                    end
                end
                ST_WSR: begin
                    eng_d.sh  = byte_in;
                    eng_d.cnt = eng_q.cnt + 1'b1;
                    if (eng_q.cnt == CNT_W'(7)) begin
                        eng_d.cnt = '0;
                        if (!eng_q.wsr_idx) begin
                            if (wr_ok) begin
                                eng_d.sr1h = byte_in[7:2];
                            end
                            eng_d.wsr_idx = 1'b1;
                        end else begin
                            if (wr_ok) begin
                                eng_d.sr2 = byte_in;
                            end
                            eng_d.st = ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end else if (fall && eng_q.st == ST_DOUT) begin
            if (eng_q.oc == 3'd0) begin
                cur      = fresh;
                eng_d.oc = lane_reload(eng_q.ln);
                if (eng_q.src == SRC_MEM) begin
                    eng_d.addr = eng_q.addr + 1'b1;
                end
            end else begin
                eng_d.oc = eng_q.oc - 1'b1;
            end
            eng_d.oe = lane_mask(eng_q.ln);
            case (eng_q.ln)
                LN_1: begin
                    eng_d.dout = {2'b00, cur[7], 1'b0};
                    eng_d.ob   = {cur[6:0], 1'b0};
                end
                LN_2: begin
                    eng_d.dout = {2'b00, cur[7:6]};
                    eng_d.ob   = {cur[5:0], 2'b00};
                end
                default: begin
                    eng_d.dout = cur[7:4];
                    eng_d.ob   = {cur[3:0], 4'h0};
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{st: ST_CMD, ln: LN_1, src: SRC_MEM, default: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign mem_raddr = eng_q.addr;
    assign lane_oe   = eng_q.oe;
    assign lane_out  = eng_q.dout;
    assign qe        = eng_q.sr2[1];
    assign wel       = eng_q.wel;
    assign sr2       = eng_q.sr2;
    assign fsm_st    = eng_q.st;
    assign fsm_cnt   = eng_q.cnt;

endmodule

// File: rtl/flash_serial_slave.sv
module flash_serial_slave
    import flash_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int ADDR_BITS  = 24,
    parameter int DUMMY_CLKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic [3:0] io_in,
    output logic [3:0] io_out,
    output logic [3:0] io_oe
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(ADDR_BITS);

    logic              sel;
    logic              rise;
    logic              fall;
    logic [3:0]        io_s;
    logic              hold_act;
    logic              wp_act;
    logic              qe;
    logic              wel;
    logic [7:0]        sr2;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [ADDR_W-1:0] mem_raddr;
    logic [7:0]        mem_wdata;
    logic [7:0]        mem_rdata;
    logic [3:0]        lane_oe;
    logic [3:0]        lane_out;
    fstate_e           fsm_st;
    logic [CNT_W-1:0]  fsm_cnt;

    flash_pin_sampler u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .cs_n     (cs_n),
        .io_in    (io_in),
        .qe       (qe),
        .sel      (sel),
        .rise     (rise),
        .fall     (fall),
        .io_s     (io_s),
        .hold_act (hold_act),
        .wp_act   (wp_act)
    );

    flash_store #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    flash_cmd_engine #(
        .ADDR_W     (ADDR_W),
        .ADDR_BITS  (ADDR_BITS),
        .DUMMY_CLKS (DUMMY_CLKS)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .rise      (rise),
        .fall      (fall),
        .io_s      (io_s),
        .wp_act    (wp_act),
        .mem_rdata (mem_rdata),
        .mem_raddr (mem_raddr),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .lane_oe   (lane_oe),
        .lane_out  (lane_out),
        .qe        (qe),
        .wel       (wel),
        .sr2       (sr2),
        .fsm_st    (fsm_st),
        .fsm_cnt   (fsm_cnt)
    );

    assign io_out = lane_out;
    assign io_oe  = lane_oe & {4{~hold_act}};

endmodule

// File: rtl/flash_slave_chk.sv
module flash_slave_chk
    import flash_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic [3:0]       io_oe,
    input logic             hold_act,
    input fstate_e          fsm_st,
    input logic [CNT_W-1:0] fsm_cnt,
    input logic             wel,
    input logic [7:0]       sr2,
    input logic             qe,
    input logic             mem_we
);

    AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> (io_oe == 4'b0000)); // R1

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_act |=> ($stable(fsm_st) && $stable(fsm_cnt))); // R5

    AST_OE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe == 4'b0000) || (io_oe == 4'b0010) || (io_oe == 4'b0011) || (io_oe == 4'b1111)); // R10

    AST_WEL_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> !cs_n); // R7

    AST_SR2_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sr2) |-> $past(wel)); // R8

    AST_PROG_NEEDS_QE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> qe); // R12

endmodule

bind flash_serial_slave flash_slave_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .io_oe    (io_oe),
    .hold_act (hold_act),
    .fsm_st   (fsm_st),
    .fsm_cnt  (fsm_cnt),
    .wel      (wel),
    .sr2      (sr2),
    .qe       (qe),
    .mem_we   (mem_we)
);

// File: tb/sim_flash_serial_slave.sv
module sim_flash_serial_slave;

    localparam int DEPTH = 64;
    localparam int HALF  = 4;
    localparam int NVEC  = 6;

    // opcode, 24-bit address, byte count
    localparam logic [39:0] VEC [NVEC] = '{
        {8'h03, 24'h000005, 8'd3},
        {8'h03, 24'hFF003E, 8'd4},
        {8'h03, 24'h000000, 8'd2},
        {8'h3B, 24'h000010, 8'd3},
        {8'h3B, 24'h00003F, 8'd2},
        {8'h03, 24'h000021, 8'd5}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic [3:0] io_in = 4'b1100;
    logic [3:0] io_out;
    logic [3:0] io_oe;
    logic       wp_pin = 1'b1;
    logic       hold_pin = 1'b1;
    logic [7:0] model [DEPTH];
    int         checks = 0;
    int         fails = 0;
    logic       done = 1'b0;

    always #4 clk = ~clk;

    flash_serial_slave u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk   (sclk),
        .cs_n   (cs_n),
        .io_in  (io_in),
        .io_out (io_out),
        .io_oe  (io_oe)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sclk_cycle(input logic [3:0] drv, output logic [3:0] seen, output logic [3:0] oe_s);
        @(negedge clk);
        sclk  = 1'b0;
        io_in = drv;
        wait_clk(HALF);
        seen = io_out;
        oe_s = io_oe;
        sclk = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic begin_tx();
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic end_tx();
        wait_clk(HALF);
        cs_n = 1'b1;
        sclk = 1'b0;
        io_in = {hold_pin, wp_pin, 2'b00};
        wait_clk(2 * HALF);
    endtask

    task automatic send_single(input logic [31:0] v, input int n);
        logic [3:0] s, o;
        for (int i = n - 1; i >= 0; i--) begin
            sclk_cycle({hold_pin, wp_pin, 1'b0, v[i]}, s, o);
        end
    endtask

    task automatic send_quad(input logic [7:0] b);
        logic [3:0] s, o;
        sclk_cycle(b[7:4], s, o);
        sclk_cycle(b[3:0], s, o);
    endtask

    task automatic dummy(input int n, output logic quiet);
        logic [3:0] s, o;
        quiet = 1'b1;
        for (int i = 0; i < n; i++) begin
            sclk_cycle({hold_pin, wp_pin, 2'b00}, s, o);
            if (o !== 4'b0000) quiet = 1'b0;
        end
    endtask

    task automatic recv(input int lanes, input int nbytes, output logic [63:0] data, output logic oe_ok);
        logic [3:0] s, o, mask;
        mask  = (lanes == 1) ? 4'b0010 : (lanes == 2) ? 4'b0011 : 4'b1111;
        data  = '0;
        oe_ok = 1'b1;
        for (int b = 0; b < nbytes; b++) begin
            for (int c = 0; c < 8 / lanes; c++) begin
                sclk_cycle({hold_pin, wp_pin, 2'b00}, s, o);
                if (o !== mask) oe_ok = 1'b0;
                case (lanes)
                    1:       data = {data[62:0], s[1]};
                    2:       data = {data[61:0], s[1:0]};
                    default: data = {data[59:0], s};
                endcase
            end
        end
    endtask

    function automatic logic [63:0] expect_bytes(input int addr, input int n);
        logic [63:0] e = '0;
        for (int k = 0; k < n; k++) begin
            e = {e[55:0], model[(addr + k) % DEPTH]};
        end
        return e;
    endfunction

    task automatic read_sr(input logic [7:0] op, output logic [7:0] v);
        logic [63:0] d;
        logic ok;
        begin_tx();
        send_single({24'h0, op}, 8);
        recv(1, 1, d, ok);
        end_tx();
        v = d[7:0];
    endtask

    task automatic wren();
        begin_tx();
        send_single(32'h06, 8);
        end_tx();
    endtask

    task automatic write_sr(input logic [7:0] b1, input logic [7:0] b2);
        begin_tx();
        send_single(32'h01, 8);
        send_single({24'h0, b1}, 8);
        send_single({24'h0, b2}, 8);
        end_tx();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        logic        ok;
        logic        quiet;
        logic [7:0]  v;
        logic [3:0]  s, o;

        for (int i = 0; i < DEPTH; i++) model[i] = 8'((i * 29) + 90);

        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        check("R1 reset outputs float", {60'h0, io_oe}, 64'h0);

        read_sr(8'h05, v);
        check("R14 SR1 reset", {56'h0, v}, 64'h00);
        read_sr(8'h35, v);
        check("R14 SR2 reset", {56'h0, v}, 64'h00);

        // vector walk: single and dual reads with wrap
        for (int k = 0; k < NVEC; k++) begin
            logic [7:0]  op;
            logic [23:0] ad;
            int          n;
            int          lanes;
            op    = VEC[k][39:32];
            ad    = VEC[k][31:8];
            n     = int'(VEC[k][7:0]);
            lanes = (op == 8'h3B) ? 2 : 1;
            begin_tx();
            send_single({24'h0, op}, 8);
            send_single({8'h0, ad}, 24);
            if (lanes == 2) begin
                dummy(8, quiet);
                check("R10 dual dummy float", {63'h0, quiet}, 64'h1);
            end
            recv(lanes, n, d, ok);
            end_tx();
            check(lanes == 2 ? "R10 dual read data" : "R3 R4 R14 single read data",
                  d, expect_bytes(int'(ad) % DEPTH, n));
            check(lanes == 2 ? "R10 dual oe" : "R3 single oe", {63'h0, ok}, 64'h1);
        end
        check("R2 deselected after vectors", {60'h0, io_oe}, 64'h0);

        // R1: partial command is discarded
        begin_tx();
        send_single(32'h0, 4);
        end_tx();
        begin_tx();
        send_single(32'h35, 8);
        recv(1, 2, d, ok);
        end_tx();
        check("R1 fresh command after partial", d, 64'h0000);

        // R13: unknown opcode
        begin_tx();
        send_single(32'h9F, 8);
        dummy(16, quiet);
        end_tx();
        check("R13 unknown opcode silent", {63'h0, quiet}, 64'h1);

        // R11: quad read ignored without quad enable
        begin_tx();
        send_single(32'h6B, 8);
        send_single(32'h000004, 24);
        dummy(16, quiet);
        end_tx();
        check("R11 quad read ignored when QE=0", {63'h0, quiet}, 64'h1);

        // R5: pause in the middle of a read
        begin_tx();
        send_single(32'h03, 8);
        send_single(32'h000005, 24);
        recv(1, 1, d, ok);
        check("R5 byte before pause", d, {56'h0, model[5]});
        @(negedge clk);
        io_in[3] = 1'b0;
        wait_clk(4);
        check("R5 outputs float while paused", {60'h0, io_oe}, 64'h0);
        quiet = 1'b1;
        for (int i = 0; i < 5; i++) begin
            sclk_cycle(4'b0101, s, o);
            if (o !== 4'b0000) quiet = 1'b0;
        end
        check("R5 clocks ignored while paused", {63'h0, quiet}, 64'h1);
        @(negedge clk);
        io_in[3] = 1'b1;
        wait_clk(4);
        recv(1, 1, d, ok);
        end_tx();
        check("R5 resume at next byte", d, {56'h0, model[6]});

        // R8: status write without write enable is dropped
        write_sr(8'hFC, 8'h02);
        read_sr(8'h35, v);
        check("R8 SR2 unchanged without WEL", {56'h0, v}, 64'h00);

        // R7: write enable sets latch and survives its own CS rise
        wren();
        read_sr(8'h05, v);
        check("R7 WEL set", {56'h0, v}, 64'h02);

        // R12: program ignored with QE=0, WEL kept
        begin_tx();
        send_single(32'h32, 8);
        send_single(32'h000008, 24);
        send_quad(8'h99);
        end_tx();
        read_sr(8'h05, v);
        check("R12 ignored program keeps WEL", {56'h0, v}, 64'h02);

        // R8: write-protect pin blocks status write
        wp_pin = 1'b0;
        write_sr(8'hFC, 8'h02);
        wp_pin = 1'b1;
        read_sr(8'h05, v);
        check("R8 R7 SR1 after protected write", {56'h0, v}, 64'h00);
        read_sr(8'h35, v);
        check("R8 SR2 after protected write", {56'h0, v}, 64'h00);

        // R6 R8: accepted status write
        wren();
        write_sr(8'h3F, 8'h02);
        read_sr(8'h05, v);
        check("R6 R7 SR1 writable bits and cleared WEL", {56'h0, v}, 64'h3C);
        begin_tx();
        send_single(32'h35, 8);
        recv(1, 2, d, ok);
        end_tx();
        check("R6 SR2 repeated read with QE", d, 64'h0202);

        // R9: IO2/IO3 are plain data with QE=1
        hold_pin = 1'b0;
        wp_pin   = 1'b0;
        begin_tx();
        send_single(32'h03, 8);
        send_single(32'h000007, 24);
        recv(1, 2, d, ok);
        end_tx();
        check("R9 no pause with QE", d, expect_bytes(7, 2));
        check("R9 oe with IO3 low", {63'h0, ok}, 64'h1);
        wren();
        write_sr(8'h40, 8'h02);
        read_sr(8'h05, v);
        check("R9 WP ignored with QE", {56'h0, v}, 64'h40);
        hold_pin = 1'b1;
        wp_pin   = 1'b1;

        // R12: program without WEL is dropped
        begin_tx();
        send_single(32'h32, 8);
        send_single(32'h00000A, 24);
        send_quad(8'h11);
        end_tx();
        begin_tx();
        send_single(32'h03, 8);
        send_single(32'h00000A, 24);
        recv(1, 1, d, ok);
        end_tx();
        check("R12 program without WEL", d, {56'h0, model[10]});

        // R12 R4: program across the wrap point
        wren();
        begin_tx();
        send_single(32'h32, 8);
        send_single(32'h00123F, 24);
        send_quad(8'hC3);
        send_quad(8'h5E);
        end_tx();
        model[63] = 8'hC3;
        model[0]  = 8'h5E;
        read_sr(8'h05, v);
        check("R7 WEL cleared after program", {56'h0, v}, 64'h40);

        // R11: quad read across wrap
        begin_tx();
        send_single(32'h6B, 8);
        send_single(32'h00003E, 24);
        dummy(8, quiet);
        check("R11 quad dummy float", {63'h0, quiet}, 64'h1);
        recv(4, 4, d, ok);
        end_tx();
        check("R11 R12 quad read data", d, expect_bytes(62, 4));
        check("R11 quad oe", {63'h0, ok}, 64'h1);
        check("R1 deselected at end", {60'h0, io_oe}, 64'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule